// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interface of a parallel flash memory as seen from the device side. It watches the host write strobe together with the address and data that the strobe carries. It recognises the multi-write unlock sequences and turns each complete sequence into a one-cycle command pulse or a change of read mode. Downstream logic uses the program pulse, with its captured address and data, to start a program operation. It uses the erase pulse to start a whole-array erase. It uses the read-mode output to choose whether reads return array contents, identification words or query-table words.

Each write is first qualified by a strobe-width filter, so a short glitch on the write line never counts. The qualified write is then compared against the expected step of the current sequence. A write that does not fit the expected step drops the sequence back to idle. While the downstream engine reports busy, qualified writes are ignored. An asynchronous reset, a three-write exit sequence, or a lone exit code returns the block to array reads.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, `read_mode` is 0 (array read) and both command pulses are low. Asserting `rst_n` in any mode returns `read_mode` to 0.
- R2: A write counts only when `we_n` was low for at least `MIN_LOW` (default 2) consecutive rising clock edges before it returns high. A shorter low pulse is not a write and does not advance a sequence.
- R3: The writes 0xAA at command address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555 arm programming. The next counted write produces `prog_pulse` for exactly one cycle, in the cycle after `we_n` returns high. In that cycle `prog_addr` and `prog_data` carry that write's full address and data.
- R4: `erase_pulse` rises for one cycle only after six writes in order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555. It rises in the cycle after the sixth strobe ends.
- R5: After the two unlock writes, a third write of 0x90 at 0x555 sets `read_mode` to 1 (identification). A third write of 0x98 at 0x555 sets `read_mode` to 2 (query table).
- R6: Two unlock writes followed by 0xF0 at 0x555 set `read_mode` to 0. So does a single write of 0xF0 at any address whenever programming is not armed.
- R7: Any counted write whose address or low data byte differs from the expected step returns the sequencer to idle with no command. This holds for a wrong address in the third step and for a wrong code in the sixth step.
- R8: Only bits [7:0] of the data and bits [CMD_ADDR_W-1:0] (default 11) of the address take part in command matching. Upper data bits have no effect.
- R9: A counted write while `busy` is high is ignored. It produces no pulse, does not change `read_mode`, and leaves the sequence position where it was.
- R10: `prog_pulse` and `erase_pulse` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset to array-read mode |
| we_n | input | 1 | Active-low write strobe from the host |
| wr_addr | input | ADDR_W (20) | Address presented with the write |
| wr_data | input | DATA_W (16) | Data presented with the write |
| busy | input | 1 | Program or erase engine is running; writes are ignored |
| prog_pulse | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W (20) | Address of the program write |
| prog_data | output | DATA_W (16) | Data of the program write |
| erase_pulse | output | 1 | One-cycle whole-array erase request |
| read_mode | output | 2 | 0 array, 1 identification, 2 query table |

## Verification
The bound checker covers several properties on every cycle. It confirms the reset state. It confirms that no pulse and no mode change follows a write made while busy. It keeps its own count of the strobe's low time and confirms that every pulse or mode change follows a strobe long enough to qualify. It also confirms that the two pulses are exclusive and last a single cycle. Some behaviour only the directed scenarios can show: that each exact sequence yields the right command, that the captured program address and data are correct, that a wrong step aborts the sequence, that upper data bits are ignored, and that a sequence interrupted by busy writes resumes where it stopped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RD_ARRAY = 2'd0,
      RD_IDENT = 2'd1,
      RD_QUERY = 2'd2
   } rd_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_KEY1  = 3'd1,
      SQ_KEY2  = 3'd2,
      SQ_ARMED = 3'd3,
      SQ_ER3   = 3'd4,
      SQ_ER4   = 3'd5,
      SQ_ER5   = 3'd6
   } seq_state_e;

   localparam logic [7:0] CODE_KEY1  = 8'hAA;
   localparam logic [7:0] CODE_KEY2  = 8'h55;
   localparam logic [7:0] CODE_PROG  = 8'hA0;
   localparam logic [7:0] CODE_ERASE = 8'h80;
   localparam logic [7:0] CODE_WHOLE = 8'h10;
   localparam logic [7:0] CODE_IDENT = 8'h90;
   localparam logic [7:0] CODE_QUERY = 8'h98;
   localparam logic [7:0] CODE_EXIT  = 8'hF0;

   localparam logic [11:0] LOC_MAIN = 12'h555;
   localparam logic [11:0] LOC_ALT  = 12'h2AA;

endpackage

// File: rtl/fcd_strobe_filter.sv
module fcd_strobe_filter #(
   parameter int MIN_LOW = 2,
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (!we_n) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   generate
      if (MIN_LOW <= 1) begin : g_flag
         logic was_low;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) was_low <= 1'b0;
            else        was_low <= !we_n;
         end
         assign wr_evt = we_n && was_low;
      end else begin : g_count
         localparam int CW = $clog2(MIN_LOW + 1);
         localparam logic [CW-1:0] SAT = CW'(MIN_LOW);
         logic [CW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           low_cnt <= '0;
            else if (we_n)        low_cnt <= '0;
            else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
         end
         assign wr_evt = we_n && (low_cnt == SAT);
      end
   endgenerate

endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int CMD_ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   output logic              prog_pulse,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_pulse,
   output rd_mode_e          read_mode
);

   localparam logic [CMD_ADDR_W-1:0] A_MAIN = CMD_ADDR_W'(LOC_MAIN);
   localparam logic [CMD_ADDR_W-1:0] A_ALT  = CMD_ADDR_W'(LOC_ALT);

   seq_state_e st, st_nx;
   rd_mode_e   mode_nx;
   logic       prog_nx, erase_nx;
   logic       take;
   logic       at_main, at_alt;
   logic [7:0] code;

   assign take    = wr_evt && !busy;
   assign code    = data_q[7:0];
   assign at_main = addr_q[CMD_ADDR_W-1:0] == A_MAIN;
   assign at_alt  = addr_q[CMD_ADDR_W-1:0] == A_ALT;

   always_comb begin
      st_nx    = st;
      mode_nx  = read_mode;
      prog_nx  = 1'b0;
      erase_nx = 1'b0;
      if (take) begin
         if (st == SQ_ARMED) begin
            prog_nx = 1'b1;
            st_nx   = SQ_IDLE;
         end else if (code == CODE_EXIT) begin
            mode_nx = RD_ARRAY;
            st_nx   = SQ_IDLE;
         end else begin
            st_nx = SQ_IDLE;
            unique case (st)
               SQ_IDLE: if (at_main && code == CODE_KEY1) st_nx = SQ_KEY1;
               SQ_KEY1: if (at_alt  && code == CODE_KEY2) st_nx = SQ_KEY2;
               SQ_KEY2: if (at_main) begin
                  unique case (code)
                     CODE_PROG:  st_nx   = SQ_ARMED;
                     CODE_ERASE: st_nx   = SQ_ER3;
                     CODE_IDENT: mode_nx = RD_IDENT;
                     CODE_QUERY: mode_nx = RD_QUERY;
                     default:    st_nx   = SQ_IDLE;
                  endcase
               end
               SQ_ER3: if (at_main && code == CODE_KEY1) st_nx = SQ_ER4;
               SQ_ER4: if (at_alt  && code == CODE_KEY2) st_nx = SQ_ER5;
               SQ_ER5: if (at_main && code == CODE_WHOLE) erase_nx = 1'b1;
               default: st_nx = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         read_mode   <= RD_ARRAY;
         prog_pulse  <= 1'b0;
         erase_pulse <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
      end else begin
         st          <= st_nx;
         read_mode   <= mode_nx;
         prog_pulse  <= prog_nx;
         erase_pulse <= erase_nx;
         if (prog_nx) begin
            prog_addr <= addr_q;
            prog_data <= data_q;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int MIN_LOW    = 2,
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int CMD_ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic              prog_pulse,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_pulse,
   output logic [1:0]        read_mode
);

   initial begin
      assert (DATA_W >= 8) else $fatal(1, "DATA_W must hold a command byte");
      assert (CMD_ADDR_W >= 11) else $fatal(1, "CMD_ADDR_W too narrow for 0x555");
      assert (ADDR_W >= CMD_ADDR_W) else $fatal(1, "ADDR_W below CMD_ADDR_W");
      assert (MIN_LOW >= 1) else $fatal(1, "MIN_LOW must be positive");
   end

   logic              wr_evt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   flash_cmd_pkg::rd_mode_e mode_w;

   fcd_strobe_filter #(
      .MIN_LOW(MIN_LOW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_filter (
      .clk(clk), .rst_n(rst_n), .we_n(we_n),
      .addr_in(wr_addr), .data_in(wr_data),
      .wr_evt(wr_evt), .addr_q(addr_q), .data_q(data_q)
   );

   fcd_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .busy(busy),
      .addr_q(addr_q), .data_q(data_q),
      .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_pulse(erase_pulse), .read_mode(mode_w)
   );

   assign read_mode = mode_w;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int MIN_LOW    = 2,
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we_n,
   input logic              busy,
   input logic              prog_pulse,
   input logic              erase_pulse,
   input logic [1:0]        read_mode
);

   localparam int CW = $clog2(MIN_LOW + 2);
   logic [CW-1:0] seen_low;
   logic          long_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      seen_low <= '0;
      else if (we_n)                   seen_low <= '0;
      else if (seen_low < CW'(MIN_LOW)) seen_low <= seen_low + 1'b1;
   end
   assign long_strobe = we_n && (seen_low >= CW'(MIN_LOW));

   // R1: reset holds array mode and quiet pulses
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |-> (read_mode == 2'd0 && !prog_pulse && !erase_pulse));

   // R2: any command effect follows a strobe of qualifying width
   assert_no_short_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_pulse || erase_pulse || !$stable(read_mode)) |-> $past(long_strobe));

   // R9: writes during busy leave everything unchanged
   assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (!prog_pulse && !erase_pulse && $stable(read_mode)));

   // R10: pulses exclusive
   assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_pulse, erase_pulse}));

   // R10: pulses last a single cycle
   assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_pulse || erase_pulse) |=> (!prog_pulse && !erase_pulse));

   // R5: read mode never takes the unused code
   assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      read_mode != 2'd3);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
   .MIN_LOW(MIN_LOW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .we_n(we_n), .busy(busy),
   .prog_pulse(prog_pulse), .erase_pulse(erase_pulse), .read_mode(read_mode)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we_n = 1'b1;
   logic [19:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy = 1'b0;
   logic        prog_pulse, erase_pulse;
   logic [19:0] prog_addr;
   logic [15:0] prog_data;
   logic [1:0]  read_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic        s_prog, s_erase;
   logic [19:0] s_paddr;
   logic [15:0] s_pdata;

   always #2.5 clk = ~clk;

   flash_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .prog_pulse(prog_pulse),
      .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_pulse(erase_pulse), .read_mode(read_mode)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // entered at a falling edge; returns at the falling edge after the
   // edge that registers the write, with outputs captured
   task automatic wr(input logic [19:0] a, input logic [15:0] d, input int lows = 2);
      we_n = 1'b0; wr_addr = a; wr_data = d;
      repeat (lows) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      s_prog = prog_pulse; s_erase = erase_pulse;
      s_paddr = prog_addr; s_pdata = prog_data;
   endtask

   task automatic unlock();
      wr(20'h00555, 16'h00AA);
      wr(20'h002AA, 16'h0055);
   endtask

   task automatic t_reset();
      check(read_mode == 2'd0, "R1 reset mode", read_mode, 0);
      check(!prog_pulse && !erase_pulse, "R1 reset pulses", {prog_pulse, erase_pulse}, 0);
   endtask

   task automatic t_program();
      unlock();
      wr(20'h00555, 16'h00A0);
      check(!s_prog, "R3 no pulse on arm", s_prog, 0);
      wr(20'h34567, 16'h1234);
      check(s_prog, "R3 program pulse", s_prog, 1);
      check(s_paddr == 20'h34567, "R3 program address", s_paddr, 20'h34567);
      check(s_pdata == 16'h1234, "R3 program data", s_pdata, 16'h1234);
      @(negedge clk);
      check(!prog_pulse, "R10 pulse one cycle", prog_pulse, 0);
      // R8: upper data byte is don't-care
      wr(20'h80555, 16'hC3AA);
      wr(20'hF02AA, 16'h7E55);
      wr(20'h10555, 16'hFFA0);
      wr(20'h00042, 16'hBEEF);
      check(s_prog && s_pdata == 16'hBEEF, "R8 upper bits ignored", s_pdata, 16'hBEEF);
   endtask

   task automatic t_erase();
      unlock();
      wr(20'h00555, 16'h0080);
      wr(20'h00555, 16'h00AA);
      wr(20'h002AA, 16'h0055);
      check(!s_erase, "R4 no erase before sixth", s_erase, 0);
      wr(20'h00555, 16'h0010);
      check(s_erase && !s_prog, "R4 erase pulse", {s_erase, s_prog}, 2'b10);
      @(negedge clk);
      check(!erase_pulse, "R10 erase one cycle", erase_pulse, 0);
   endtask

   task automatic t_modes();
      unlock(); wr(20'h00555, 16'h0090);
      check(read_mode == 2'd1, "R5 ident mode", read_mode, 1);
      unlock(); wr(20'h00555, 16'h00F0);
      check(read_mode == 2'd0, "R6 three-write exit", read_mode, 0);
      unlock(); wr(20'h00555, 16'h0098);
      check(read_mode == 2'd2, "R5 query mode", read_mode, 2);
      wr(20'h77777, 16'h00F0);
      check(read_mode == 2'd0, "R6 single exit", read_mode, 0);
   endtask

   task automatic t_mismatch();
      unlock(); wr(20'h00554, 16'h00A0);
      wr(20'h00100, 16'h5A5A);
      check(!s_prog, "R7 wrong address aborts", s_prog, 0);
      unlock();
      wr(20'h00555, 16'h0080); wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055);
      wr(20'h00555, 16'h0030);
      check(!s_erase, "R7 wrong final code", s_erase, 0);
      wr(20'h00555, 16'h0010);
      check(!s_erase, "R7 sequence restarted", s_erase, 0);
   endtask

   task automatic t_glitch();
      wr(20'h00555, 16'h00AA);
      wr(20'h002AA, 16'h0055, 1);
      wr(20'h00555, 16'h0098);
      check(read_mode == 2'd0, "R2 short strobe not counted", read_mode, 0);
      unlock(); wr(20'h00555, 16'h0090, 1);
      check(read_mode == 2'd0, "R2 short third write", read_mode, 0);
      wr(20'h00555, 16'h0090, 3);
      check(read_mode == 2'd1, "R2 long strobe counts", read_mode, 1);
      wr(20'h00000, 16'h00F0);
   endtask

   task automatic t_busy();
      unlock();
      busy = 1'b1;
      wr(20'h00555, 16'h0090);
      check(read_mode == 2'd0, "R9 busy ignores entry", read_mode, 0);
      busy = 1'b0;
      wr(20'h00555, 16'h0098);
      check(read_mode == 2'd2, "R9 position kept", read_mode, 2);
      busy = 1'b1;
      wr(20'h00000, 16'h00F0);
      check(read_mode == 2'd2, "R9 busy ignores exit", read_mode, 2);
      busy = 1'b0;
   endtask

   task automatic t_reset_mid();
      rst_n = 1'b0;
      #1;
      check(read_mode == 2'd0, "R1 async reset clears mode", read_mode, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(read_mode == 2'd0, "R1 stays array after reset", read_mode, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_program();
      t_erase();
      t_modes();
      t_mismatch();
      t_glitch();
      t_busy();
      t_reset_mid();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule